// File: doc/BRIEF.md
# Raster/Linear Interrupt Timer

This block is a free-running position timer. On every tick strobe it moves a horizontal counter forward by two clock units and derives a vertical counter from it. Two counting schemes are available. The raster scheme models a display line of 1364 clocks and a frame of 262 or 312 lines, chosen by a region input. The linear scheme treats the pair as one binary count: an 11-bit horizontal part whose overflow carries into a 9-bit vertical part.

Software programs a horizontal compare value in dot units, where one dot is four clocks, and a vertical compare value in lines. Two enable bits choose the match condition: horizontal only, vertical only (at the start of the line), both, or none. On a match the block always raises its timer flag. It also drops its clear latch, which unmasks the interrupt, but only when the interrupt enable is set. An acknowledge strobe lowers the flag and sets the latch again. A snapshot strobe copies both counters into holding registers, so a reader that takes several bytes sees one consistent position.

Top module: `irq_pos_timer`

## Requirements
- R1: While reset is low, both counters, both snapshot registers, the timer flag and the clear latch are all 0.
- R2: Each cycle with `tick` high adds 2 to the horizontal counter. Cycles without `tick` leave both counters unchanged.
- R3: In raster mode (`linearMode` = 0), a tick that brings the horizontal count to 1364 or more sets it to 0 and adds 1 to the vertical counter. A vertical count that reaches the frame's line count becomes 0.
- R4: The frame's line count is 262 when `region50` = 0 and 312 when `region50` = 1.
- R5: In linear mode (`linearMode` = 1), the horizontal counter keeps 11 bits and its overflow adds 1 to the vertical counter, which keeps 9 bits and wraps from 511 to 0.
- R6: With the match mode {`vMatchEn`,`hMatchEn`} = 2'b00, the flag is never raised.
- R7: Mode 2'b01 matches when the horizontal counter equals `hCompare` × 4.
- R8: Mode 2'b10 matches when the vertical counter equals `vCompare` and the horizontal counter is 0.
- R9: Mode 2'b11 matches when the vertical counter equals `vCompare` and the horizontal counter equals `hCompare` × 4.
- R10: A match is tested only in tick cycles, against the counter values that tick produces. The flag rises in the same edge as the counters.
- R11: A match sets `timerFlag`. It clears `clearLatch` only if `irqEnable` is 1. Otherwise the latch keeps its value.
- R12: `ackReq` clears `timerFlag` and sets `clearLatch`. If a match falls in the same cycle, the match wins for both.
- R13: `snapReq` copies the counter values held before that cycle's tick into `hSnap`/`vSnap`. At all other times the snapshots hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Advance strobe, one step of 2 clocks |
| snapReq | input | 1 | Copy counters into snapshot registers |
| ackReq | input | 1 | Acknowledge: clear flag, set clear latch |
| linearMode | input | 1 | 0 raster counting, 1 linear counting |
| hMatchEn | input | 1 | Horizontal compare enable (mode bit 0) |
| vMatchEn | input | 1 | Vertical compare enable (mode bit 1) |
| hCompare | input | 9 | Horizontal compare value in dots |
| vCompare | input | 9 | Vertical compare value in lines |
| irqEnable | input | 1 | Timer interrupt enable |
| region50 | input | 1 | 0: 262-line frame, 1: 312-line frame |
| timerFlag | output | 1 | Timer match flag |
| clearLatch | output | 1 | Interrupt clear latch (1 = masked) |
| hCount | output | 11 | Live horizontal counter in clocks |
| vCount | output | 9 | Live vertical counter |
| hSnap | output | 11 | Captured horizontal counter |
| vSnap | output | 9 | Captured vertical counter |

## Verification
Two functions can fall in the same edge. A compare match can coincide with an acknowledge, and a snapshot can coincide with a tick. The bench provokes the first by holding `ackReq` high during the tick that reaches the compare point. It expects the flag set and the latch cleared, and a later lone acknowledge must then reverse both. It provokes the second by asserting `snapReq` together with `tick`, and expects the snapshot to hold the pre-tick count while the live counter has already moved on by 2.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

  // Strobes handed from the control module to the datapath.
  typedef struct packed {
    logic advance;
    logic capture;
  } tmrStrobe_t;

  // Match condition selected by {vertical enable, horizontal enable}.
  typedef enum logic [1:0] {
    MATCH_OFF = 2'b00,
    MATCH_H   = 2'b01,
    MATCH_V   = 2'b10,
    MATCH_HV  = 2'b11
  } matchMode_t;

endpackage

// File: rtl/irq_timer_dp.sv
module irq_timer_dp
  import irq_timer_pkg::*;
#(
  parameter int H_WIDTH     = 11,
  parameter int V_WIDTH     = 9,
  parameter int STEP        = 2,
  parameter int LINE_CLOCKS = 1364,
  parameter int LINES_60    = 262,
  parameter int LINES_50    = 312
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tmrStrobe_t         strobe,
  input  logic               linearMode,
  input  logic               region50,
  output logic [H_WIDTH-1:0] hCount,
  output logic [V_WIDTH-1:0] vCount,
  output logic [H_WIDTH-1:0] hSnap,
  output logic [V_WIDTH-1:0] vSnap,
  output logic [H_WIDTH-1:0] hNext,
  output logic [V_WIDTH-1:0] vNext
);

  localparam int HX = H_WIDTH + 1;
  localparam int VX = V_WIDTH + 1;
  localparam logic [HX-1:0] STEP_X  = HX'(STEP);
  localparam logic [HX-1:0] LINE_X  = HX'(LINE_CLOCKS);
  localparam logic [VX-1:0] FRAME60 = VX'(LINES_60);
  localparam logic [VX-1:0] FRAME50 = VX'(LINES_50);

  logic [HX-1:0] hSum;
  logic [VX-1:0] vInc;
  logic [VX-1:0] frameLines;
  logic          lineDone;

  assign hSum       = {1'b0, hCount} + STEP_X;
  assign vInc       = {1'b0, vCount} + VX'(1);
  assign frameLines = region50 ? FRAME50 : FRAME60;
  assign lineDone   = (hSum >= LINE_X);

  // Counter values that the next tick would produce.
  always_comb begin
    if (linearMode) begin
      hNext = hSum[H_WIDTH-1:0];
      vNext = vCount + V_WIDTH'(hSum[H_WIDTH]);
    end else if (lineDone) begin
      hNext = '0;
      vNext = (vInc >= frameLines) ? '0 : vInc[V_WIDTH-1:0];
    end else begin
      hNext = hSum[H_WIDTH-1:0];
      vNext = vCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hCount <= '0;
      vCount <= '0;
    end else if (strobe.advance) begin
      hCount <= hNext;
      vCount <= vNext;
    end
  end

  // Snapshot takes the values held before this cycle's advance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hSnap <= '0;
      vSnap <= '0;
    end else if (strobe.capture) begin
      hSnap <= hCount;
      vSnap <= vCount;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.advance |=> $stable(hCount) && $stable(vCount)); // R2

  AST_RASTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.advance && !linearMode && ({1'b0, hCount} + STEP_X >= LINE_X)
      |=> hCount == '0); // R3

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> $stable(hSnap) && $stable(vSnap)); // R13

endmodule

// File: rtl/irq_timer_match.sv
module irq_timer_match
  import irq_timer_pkg::*;
#(
  parameter int H_WIDTH   = 11,
  parameter int V_WIDTH   = 9,
  parameter int CMP_WIDTH = 9,
  parameter int DOT_SHIFT = 2
) (
  input  logic                 advance,
  input  logic [H_WIDTH-1:0]   hNext,
  input  logic [V_WIDTH-1:0]   vNext,
  input  logic [CMP_WIDTH-1:0] hCompare,
  input  logic [CMP_WIDTH-1:0] vCompare,
  input  logic                 hMatchEn,
  input  logic                 vMatchEn,
  output logic                 hit
);

  localparam int WIDE = CMP_WIDTH + DOT_SHIFT;

  logic [WIDE-1:0]    hDots;
  logic [H_WIDTH-1:0] hTarget;
  logic [V_WIDTH-1:0] vTarget;
  logic               hEq;
  logic               vEq;
  logic               hZero;
  matchMode_t         mode;

  // Compare value is in dots; counters run in clocks.
  assign hDots   = {{DOT_SHIFT{1'b0}}, hCompare} << DOT_SHIFT;
  assign hTarget = H_WIDTH'(hDots);
  assign vTarget = V_WIDTH'(vCompare);
  assign hEq     = (hNext == hTarget);
  assign vEq     = (vNext == vTarget);
  assign hZero   = (hNext == '0);
  assign mode    = matchMode_t'({vMatchEn, hMatchEn});

  always_comb begin
    unique case (mode)
      MATCH_OFF: hit = 1'b0;
      MATCH_H:   hit = advance && hEq;
      MATCH_V:   hit = advance && vEq && hZero;
      MATCH_HV:  hit = advance && vEq && hEq;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_timer_ctrl.sv
module irq_timer_ctrl
  import irq_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       snapReq,
  input  logic       ackReq,
  input  logic       irqEnable,
  input  logic       hMatchEn,
  input  logic       vMatchEn,
  input  logic       hit,
  output tmrStrobe_t strobe,
  output logic       timerFlag,
  output logic       clearLatch
);

  assign strobe.advance = tick;
  assign strobe.capture = snapReq;

  // A match outranks an acknowledge in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timerFlag  <= 1'b0;
      clearLatch <= 1'b0;
    end else begin
      if (hit)         timerFlag <= 1'b1;
      else if (ackReq) timerFlag <= 1'b0;

      if (hit && irqEnable) clearLatch <= 1'b0;
      else if (ackReq)      clearLatch <= 1'b1;
    end
  end

  AST_NO_FIRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !hMatchEn && !vMatchEn |=> !$rose(timerFlag)); // R6

  AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !ackReq |=> $stable(timerFlag)); // R10

  AST_LATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !irqEnable |=> !$fell(clearLatch)); // R11

  AST_ACK_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    ackReq && !hit |=> !timerFlag && clearLatch); // R12

endmodule

// File: rtl/irq_pos_timer.sv
module irq_pos_timer
  import irq_timer_pkg::*;
#(
  parameter int H_WIDTH     = 11,
  parameter int V_WIDTH     = 9,
  parameter int CMP_WIDTH   = 9,
  parameter int DOT_SHIFT   = 2,
  parameter int STEP        = 2,
  parameter int LINE_CLOCKS = 1364,
  parameter int LINES_60    = 262,
  parameter int LINES_50    = 312
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 snapReq,
  input  logic                 ackReq,
  input  logic                 linearMode,
  input  logic                 hMatchEn,
  input  logic                 vMatchEn,
  input  logic [CMP_WIDTH-1:0] hCompare,
  input  logic [CMP_WIDTH-1:0] vCompare,
  input  logic                 irqEnable,
  input  logic                 region50,
  output logic                 timerFlag,
  output logic                 clearLatch,
  output logic [H_WIDTH-1:0]   hCount,
  output logic [V_WIDTH-1:0]   vCount,
  output logic [H_WIDTH-1:0]   hSnap,
  output logic [V_WIDTH-1:0]   vSnap
);

  tmrStrobe_t         strobe;
  logic [H_WIDTH-1:0] hNext;
  logic [V_WIDTH-1:0] vNext;
  logic               hit;

  irq_timer_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .snapReq    (snapReq),
    .ackReq     (ackReq),
    .irqEnable  (irqEnable),
    .hMatchEn   (hMatchEn),
    .vMatchEn   (vMatchEn),
    .hit        (hit),
    .strobe     (strobe),
    .timerFlag  (timerFlag),
    .clearLatch (clearLatch)
  );

  irq_timer_dp #(
    .H_WIDTH     (H_WIDTH),
    .V_WIDTH     (V_WIDTH),
    .STEP        (STEP),
    .LINE_CLOCKS (LINE_CLOCKS),
    .LINES_60    (LINES_60),
    .LINES_50    (LINES_50)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .linearMode (linearMode),
    .region50   (region50),
    .hCount     (hCount),
    .vCount     (vCount),
    .hSnap      (hSnap),
    .vSnap      (vSnap),
    .hNext      (hNext),
    .vNext      (vNext)
  );

  irq_timer_match #(
    .H_WIDTH   (H_WIDTH),
    .V_WIDTH   (V_WIDTH),
    .CMP_WIDTH (CMP_WIDTH),
    .DOT_SHIFT (DOT_SHIFT)
  ) u_match (
    .advance  (strobe.advance),
    .hNext    (hNext),
    .vNext    (vNext),
    .hCompare (hCompare),
    .vCompare (vCompare),
    .hMatchEn (hMatchEn),
    .vMatchEn (vMatchEn),
    .hit      (hit)
  );

endmodule

// File: tb/irq_pos_timer_tb.sv
module irq_pos_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       snapReq = 1'b0;
  logic       ackReq = 1'b0;
  logic       linearMode = 1'b0;
  logic       hMatchEn = 1'b0;
  logic       vMatchEn = 1'b0;
  logic [8:0] hCompare = '0;
  logic [8:0] vCompare = '0;
  logic       irqEnable = 1'b0;
  logic       region50 = 1'b0;

  logic        timerFlag, clearLatch;
  logic [10:0] hCount, hSnap;
  logic [8:0]  vCount, vSnap;

  // Short-line copy: 16-clock lines, 5-bit horizontal count, for frame wraps.
  logic        sFlag, sClr;
  logic [4:0]  sH, sHSnap;
  logic [8:0]  sV, sVSnap;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_pos_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .snapReq(snapReq), .ackReq(ackReq),
    .linearMode(linearMode), .hMatchEn(hMatchEn), .vMatchEn(vMatchEn),
    .hCompare(hCompare), .vCompare(vCompare), .irqEnable(irqEnable),
    .region50(region50), .timerFlag(timerFlag), .clearLatch(clearLatch),
    .hCount(hCount), .vCount(vCount), .hSnap(hSnap), .vSnap(vSnap)
  );

  irq_pos_timer #(.H_WIDTH(5), .LINE_CLOCKS(16)) u_dut_short (
    .clk(clk), .rst_n(rst_n), .tick(tick), .snapReq(snapReq), .ackReq(ackReq),
    .linearMode(linearMode), .hMatchEn(hMatchEn), .vMatchEn(vMatchEn),
    .hCompare(hCompare), .vCompare(vCompare), .irqEnable(irqEnable),
    .region50(region50), .timerFlag(sFlag), .clearLatch(sClr),
    .hCount(sH), .vCount(sV), .hSnap(sHSnap), .vSnap(sVSnap)
  );

  typedef struct packed {
    logic        lin;
    logic [1:0]  mode;   // {vMatchEn, hMatchEn}
    logic [8:0]  hc;
    logic [8:0]  vc;
    logic        en;
    logic [15:0] n;
    logic [10:0] eh;
    logic [8:0]  ev;
    logic        ef;
    logic        ec;
  } vec_t;

  // After reset and one acknowledge: flag 0, latch 1; then n ticks.
  localparam vec_t VECS [12] = '{
    '{1'b0, 2'd0, 9'd0,   9'd0, 1'b1, 16'd10,   11'd20,   9'd0, 1'b0, 1'b1}, // R2 R6
    '{1'b0, 2'd0, 9'd0,   9'd0, 1'b1, 16'd682,  11'd0,    9'd1, 1'b0, 1'b1}, // R3
    '{1'b0, 2'd1, 9'd5,   9'd0, 1'b1, 16'd10,   11'd20,   9'd0, 1'b1, 1'b0}, // R7 R11
    '{1'b0, 2'd1, 9'd5,   9'd0, 1'b0, 16'd10,   11'd20,   9'd0, 1'b1, 1'b1}, // R11
    '{1'b0, 2'd1, 9'd5,   9'd0, 1'b1, 16'd9,    11'd18,   9'd0, 1'b0, 1'b1}, // R7
    '{1'b0, 2'd2, 9'd0,   9'd1, 1'b1, 16'd682,  11'd0,    9'd1, 1'b1, 1'b0}, // R8
    '{1'b0, 2'd2, 9'd0,   9'd0, 1'b1, 16'd681,  11'd1362, 9'd0, 1'b0, 1'b1}, // R10
    '{1'b0, 2'd3, 9'd3,   9'd1, 1'b1, 16'd688,  11'd12,   9'd1, 1'b1, 1'b0}, // R9
    '{1'b0, 2'd3, 9'd3,   9'd1, 1'b1, 16'd6,    11'd12,   9'd0, 1'b0, 1'b1}, // R9
    '{1'b1, 2'd0, 9'd0,   9'd0, 1'b1, 16'd1024, 11'd0,    9'd1, 1'b0, 1'b1}, // R5
    '{1'b0, 2'd1, 9'd0,   9'd0, 1'b1, 16'd682,  11'd0,    9'd1, 1'b1, 1'b0}, // R10
    '{1'b1, 2'd1, 9'd500, 9'd0, 1'b1, 16'd1000, 11'd2000, 9'd0, 1'b1, 1'b0}  // R5 R7
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 1'b0; snapReq = 1'b0; ackReq = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ack_once();
    ackReq = 1'b1;
    @(negedge clk);
    ackReq = 1'b0;
  endtask

  task automatic run(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 hCount", hCount, 0);
    chk("R1 vCount", vCount, 0);
    chk("R1 hSnap", hSnap, 0);
    chk("R1 vSnap", vSnap, 0);
    chk("R1 flag", timerFlag, 0);
    chk("R1 latch", clearLatch, 0);

    // Vector table
    foreach (VECS[i]) begin
      linearMode = VECS[i].lin;
      {vMatchEn, hMatchEn} = VECS[i].mode;
      hCompare = VECS[i].hc;
      vCompare = VECS[i].vc;
      irqEnable = VECS[i].en;
      region50 = 1'b0;
      do_reset();
      ack_once();
      run(int'(VECS[i].n));
      chk($sformatf("R2 row%0d hCount", i), hCount, int'(VECS[i].eh));
      chk($sformatf("R3 row%0d vCount", i), vCount, int'(VECS[i].ev));
      chk($sformatf("R11 row%0d flag", i), timerFlag, int'(VECS[i].ef));
      chk($sformatf("R11 row%0d latch", i), clearLatch, int'(VECS[i].ec));
    end

    // R2: no tick, no motion
    repeat (5) @(negedge clk);
    chk("R2 idle hCount", hCount, 2000);
    chk("R2 idle vCount", vCount, 0);

    // R1: reset mid-run
    do_reset();
    chk("R1 mid-run hCount", hCount, 0);
    chk("R1 mid-run flag", timerFlag, 0);

    // R13: snapshot, lone and coincident with tick
    linearMode = 1'b0; {vMatchEn, hMatchEn} = 2'b00; irqEnable = 1'b0;
    do_reset();
    run(7);
    snapReq = 1'b1; @(negedge clk); snapReq = 1'b0;
    chk("R13 hSnap lone", hSnap, 14);
    chk("R13 vSnap lone", vSnap, 0);
    run(3);
    tick = 1'b1; snapReq = 1'b1; @(negedge clk); tick = 1'b0; snapReq = 1'b0;
    chk("R13 hSnap with tick", hSnap, 20);
    chk("R13 hCount with snap", hCount, 22);
    run(5);
    chk("R13 hSnap hold", hSnap, 20);
    chk("R13 hCount after", hCount, 32);

    // R12: match and acknowledge in one cycle
    {vMatchEn, hMatchEn} = 2'b01; hCompare = 9'd5; irqEnable = 1'b1;
    do_reset();
    ack_once();
    run(9);
    tick = 1'b1; ackReq = 1'b1; @(negedge clk); tick = 1'b0; ackReq = 1'b0;
    chk("R12 collide hCount", hCount, 20);
    chk("R12 collide flag", timerFlag, 1);
    chk("R12 collide latch", clearLatch, 0);
    ack_once();
    chk("R12 lone ack flag", timerFlag, 0);
    chk("R12 lone ack latch", clearLatch, 1);

    // R4: frame length per region (short-line copy, 8 ticks per line)
    {vMatchEn, hMatchEn} = 2'b00; irqEnable = 1'b0; linearMode = 1'b0;
    region50 = 1'b0;
    do_reset();
    run(2095);
    chk("R4 60Hz last line", sV, 261);
    chk("R4 60Hz last h", sH, 14);
    run(1);
    chk("R4 60Hz wrap v", sV, 0);
    chk("R4 60Hz wrap h", sH, 0);
    region50 = 1'b1;
    do_reset();
    run(2095);
    chk("R4 50Hz no wrap at 262", sV, 261);
    run(400);
    chk("R4 50Hz last line", sV, 311);
    run(1);
    chk("R4 50Hz wrap v", sV, 0);

    // R5: linear vertical wrap (short copy: 16 ticks per carry)
    region50 = 1'b0; linearMode = 1'b1;
    do_reset();
    run(8191);
    chk("R5 linear top v", sV, 511);
    chk("R5 linear top h", sH, 30);
    run(1);
    chk("R5 linear wrap v", sV, 0);
    chk("R5 linear wrap h", sH, 0);

    finish_up();
  end

endmodule